// File: doc/BRIEF.md
# Page Dirty-Tracking Refresh Scanner

This block keeps one dirty flag for every page of a frame buffer and, when a refresh is requested, walks those flags from the top of the screen to the bottom at one page per clock. Each page stands for a band of four display lines. Consecutive dirty pages are merged into a single update rectangle, reported as a start line, a line count and the configured display width. The display path then repaints only those bands.

Flags are set by snooped writes to any of three planes: the 8-bit index plane, the direct-colour plane and the control plane. A whole-screen invalidate or a palette change marks every page of the index plane, and in 24-bit mode the other two planes as well. In 24-bit mode a page band is dirty when any plane has its flag set. In 8-bit mode only the index plane counts. During a scan the block tracks the lowest and the highest dirty page it found. When the scan ends, it clears the flags of every plane over that inclusive page window. A page that was written while the scan ran keeps its flags, so the next refresh still repaints it.

Top module: `page_dirty_scanner`

## Requirements
- R1: After reset all dirty flags are clear, the scanner is idle, and `rect_valid`, `rect_y`, `rect_h`, `rect_w` and `scan_done` are all 0.
- R2: A `scan_start` seen while idle examines page k (lines 4k to 4k+3) in the k-th cycle after the start edge, for pages 0 to NUM_PAGES-1. One more cycle then ends the scan, and `scan_done` is high for exactly that single cycle. With 16 pages, `scan_done` is first seen high 17 clock edges after the edge that accepted the start.
- R3: A run of dirty pages that begins at page s and meets its first clean page at page c produces one rectangle with `rect_y` = 4s and `rect_h` = 4(c-s). `rect_valid` is high for one cycle, in the cycle after page c is examined.
- R4: A run that is still open after the last page produces a rectangle with `rect_y` = 4s and `rect_h` = 4·NUM_PAGES-4s, in the same cycle as `scan_done`.
- R5: At the end of a scan, if any dirty page was found, the flags of all three planes are cleared for every page from the lowest to the highest dirty page found, inclusive. Flags outside that window are kept. This holds even for planes that did not count towards the scan.
- R6: `snoop_valid` sets the flag of page `snoop_page` in plane `snoop_plane` (0 = index plane, 1 = direct-colour plane, 2 = control plane). A snoop that lands while a scan is running, including in its final cycle, marks that page as protected, and the end-of-scan clear leaves that page's flags set.
- R7: `invalidate` or `palette_chg` sets every page flag of the index plane, and also of the direct-colour and control planes when `mode_24` is 1.
- R8: With `mode_24` = 1 a page is dirty if its flag is set in any of the three planes. With `mode_24` = 0 only the index-plane flag is looked at.
- R9: `rect_w` of every rectangle equals the value of `disp_width` sampled at the clock edge that produced the rectangle.
- R10: `scan_start` while a scan is running is ignored: no second scan and no extra `scan_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_24 | input | 1 | 1 = 24-bit mode (all three planes count), 0 = 8-bit mode |
| disp_width | input | WIDTH_W | Display width reported with every rectangle |
| snoop_valid | input | 1 | A write to a frame-buffer page was observed |
| snoop_plane | input | 2 | Plane written: 0 index, 1 direct colour, 2 control |
| snoop_page | input | PAGE_W | Page number written |
| invalidate | input | 1 | Mark the whole frame buffer dirty |
| palette_chg | input | 1 | Palette changed; mark the whole frame buffer dirty |
| scan_start | input | 1 | Begin a refresh scan (accepted only when idle) |
| rect_valid | output | 1 | One-cycle strobe: a rectangle is presented |
| rect_y | output | LINE_W | First display line of the rectangle |
| rect_h | output | LINE_W | Number of display lines in the rectangle |
| rect_w | output | WIDTH_W | Width of the rectangle |
| scan_done | output | 1 | One-cycle strobe at the end of a scan |

## Verification
Two things can happen to the same page flag in one cycle: a snooped write that sets it, and the end-of-scan clear of the min-to-max window. They also overlap at a coarser grain, because a write that lands during a scan on a page already examined would otherwise be wiped by that clear. The bench writes to a page inside the window both before the scan and again after the scan has passed it. It also issues scan starts while the scan is running. A behavioural reference model predicts every rectangle, strobe and width cycle by cycle, and the following refresh must report the protected page again.

// File: rtl/pds_pkg.sv
package pds_pkg;

    localparam int PLANE_CNT = 3;

    typedef enum logic [1:0] {
        PL_INDEX  = 2'd0,
        PL_DIRECT = 2'd1,
        PL_CTRL   = 2'd2
    } plane_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } scan_state_t;

    // window test used for the end-of-scan clear
    function automatic logic in_window(input int idx, input int lo, input int hi);
        return (idx >= lo) && (idx <= hi);
    endfunction

endpackage

// File: rtl/pds_plane_bits.sv
module pds_plane_bits #(
    parameter int NUM_PAGES = 16,
    parameter int PAGE_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_one,
    input  logic [PAGE_W-1:0]    set_page,
    input  logic                 set_all,
    input  logic [NUM_PAGES-1:0] clr_mask,
    output logic [NUM_PAGES-1:0] bits
);
    logic [NUM_PAGES-1:0] set_vec;

    always_comb begin
        set_vec = set_all ? '1 : '0;
        if (set_one && (int'(set_page) < NUM_PAGES))
            set_vec[set_page] = 1'b1;
    end

    // a set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst)
            bits <= '0;
        else
            bits <= (bits & ~clr_mask) | set_vec;
    end
endmodule

// File: rtl/pds_run_tracker.sv
module pds_run_tracker #(
    parameter int NUM_PAGES      = 16,
    parameter int LINES_PER_PAGE = 4,
    parameter int PAGE_W         = 4,
    parameter int LINE_W         = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              step,
    input  logic              step_dirty,
    input  logic [PAGE_W-1:0] step_page,
    input  logic              flush,
    output logic              emit,
    output logic [LINE_W-1:0] emit_y,
    output logic [LINE_W-1:0] emit_h,
    output logic [PAGE_W:0]   lo_page,
    output logic [PAGE_W:0]   hi_page
);
    localparam int TOTAL_LINES = NUM_PAGES * LINES_PER_PAGE;

    logic              run_open;
    logic [PAGE_W-1:0] run_start;
    logic [PAGE_W:0]   page_ext;

    function automatic logic [LINE_W-1:0] line_of(input logic [PAGE_W-1:0] pg);
        return LINE_W'(int'(pg) * LINES_PER_PAGE);
    endfunction

    assign page_ext = {1'b0, step_page};

    always_ff @(posedge clk) begin
        if (rst) begin
            emit      <= 1'b0;
            emit_y    <= '0;
            emit_h    <= '0;
            run_open  <= 1'b0;
            run_start <= '0;
            lo_page   <= '1;
            hi_page   <= '0;
        end else begin
            emit <= 1'b0;
            if (init) begin
                run_open <= 1'b0;
                lo_page  <= '1;
                hi_page  <= '0;
            end else if (step) begin
                if (step_dirty) begin
                    if (!run_open) begin
                        run_open  <= 1'b1;
                        run_start <= step_page;
                    end
                    if (page_ext < lo_page) lo_page <= page_ext;
                    if (page_ext > hi_page) hi_page <= page_ext;
                end else if (run_open) begin
                    emit     <= 1'b1;
                    emit_y   <= line_of(run_start);
                    emit_h   <= line_of(step_page) - line_of(run_start);
                    run_open <= 1'b0;
                end
            end else if (flush && run_open) begin
                emit     <= 1'b1;
                emit_y   <= line_of(run_start);
                emit_h   <= LINE_W'(TOTAL_LINES) - line_of(run_start);
                run_open <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/page_dirty_scanner.sv
module page_dirty_scanner
    import pds_pkg::*;
#(
    parameter int NUM_PAGES      = 16,
    parameter int LINES_PER_PAGE = 4,
    parameter int WIDTH_W        = 11,
    localparam int PAGE_W        = $clog2(NUM_PAGES),
    localparam int LINE_W        = $clog2(NUM_PAGES * LINES_PER_PAGE + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_24,
    input  logic [WIDTH_W-1:0] disp_width,
    input  logic               snoop_valid,
    input  logic [1:0]         snoop_plane,
    input  logic [PAGE_W-1:0]  snoop_page,
    input  logic               invalidate,
    input  logic               palette_chg,
    input  logic               scan_start,
    output logic               rect_valid,
    output logic [LINE_W-1:0]  rect_y,
    output logic [LINE_W-1:0]  rect_h,
    output logic [WIDTH_W-1:0] rect_w,
    output logic               scan_done
);
    scan_state_t          state;
    logic [PAGE_W-1:0]    scan_idx;
    logic [NUM_PAGES-1:0] plane_bits [PLANE_CNT];
    logic [NUM_PAGES-1:0] protect_q;
    logic [NUM_PAGES-1:0] clr_mask;
    logic [NUM_PAGES-1:0] snoop_vec;
    logic [PAGE_W:0]      lo_page, hi_page;
    logic                 page_dirty;
    logic                 mark_all;
    logic                 start_ok;
    logic                 in_scan;
    logic                 in_finish;

    assign start_ok  = (state == ST_IDLE) && scan_start;
    assign in_scan   = (state == ST_SCAN);
    assign in_finish = (state == ST_FINISH);
    assign mark_all  = invalidate || palette_chg;

    // dirty flag storage, one instance per plane
    for (genvar p = 0; p < PLANE_CNT; p++) begin : g_plane
        logic set_all_p;
        if (p == int'(PL_INDEX)) begin : g_idx
            assign set_all_p = mark_all;
        end else begin : g_aux
            assign set_all_p = mark_all && mode_24;
        end
        pds_plane_bits #(
            .NUM_PAGES (NUM_PAGES),
            .PAGE_W    (PAGE_W)
        ) u_bits (
            .clk      (clk),
            .rst      (rst),
            .set_one  (snoop_valid && (snoop_plane == 2'(p))),
            .set_page (snoop_page),
            .set_all  (set_all_p),
            .clr_mask (clr_mask),
            .bits     (plane_bits[p])
        );
    end

    // page band is dirty from the index plane, or any plane in 24-bit mode
    always_comb begin
        page_dirty = plane_bits[PL_INDEX][scan_idx];
        if (mode_24)
            page_dirty = page_dirty || plane_bits[PL_DIRECT][scan_idx]
                                    || plane_bits[PL_CTRL][scan_idx];
    end

    always_comb begin
        snoop_vec = '0;
        if (snoop_valid && (int'(snoop_page) < NUM_PAGES))
            snoop_vec[snoop_page] = 1'b1;
        if (invalidate || palette_chg)
            snoop_vec = '1;
    end

    // end-of-scan clear of the lowest..highest window, minus protected pages
    always_comb begin
        clr_mask = '0;
        if (in_finish && (hi_page >= lo_page)) begin
            for (int i = 0; i < NUM_PAGES; i++)
                clr_mask[i] = in_window(i, int'(lo_page), int'(hi_page)) && !protect_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            scan_idx  <= '0;
            protect_q <= '0;
            scan_done <= 1'b0;
            rect_w    <= '0;
        end else begin
            scan_done <= in_finish;
            rect_w    <= disp_width;
            case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        state     <= ST_SCAN;
                        scan_idx  <= '0;
                        protect_q <= '0;
                    end
                end
                ST_SCAN: begin
                    protect_q <= protect_q | snoop_vec;
                    if (scan_idx == PAGE_W'(NUM_PAGES - 1))
                        state <= ST_FINISH;
                    else
                        scan_idx <= scan_idx + 1'b1;
                end
                ST_FINISH: begin
                    protect_q <= protect_q | snoop_vec;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    pds_run_tracker #(
        .NUM_PAGES      (NUM_PAGES),
        .LINES_PER_PAGE (LINES_PER_PAGE),
        .PAGE_W         (PAGE_W),
        .LINE_W         (LINE_W)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .init       (start_ok),
        .step       (in_scan),
        .step_dirty (page_dirty),
        .step_page  (scan_idx),
        .flush      (in_finish),
        .emit       (rect_valid),
        .emit_y     (rect_y),
        .emit_h     (rect_h),
        .lo_page    (lo_page),
        .hi_page    (hi_page)
    );
endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
    parameter int NUM_PAGES      = 16,
    parameter int LINES_PER_PAGE = 4,
    parameter int WIDTH_W        = 11,
    parameter int LINE_W         = 7
) (
    input logic               clk,
    input logic               rst,
    input logic [WIDTH_W-1:0] disp_width,
    input logic               rect_valid,
    input logic [LINE_W-1:0]  rect_y,
    input logic [LINE_W-1:0]  rect_h,
    input logic [WIDTH_W-1:0] rect_w,
    input logic               scan_done
);
    localparam int TOTAL_LINES = NUM_PAGES * LINES_PER_PAGE;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> !scan_done);

    // R3
    rect_gap_chk: assert property (@(posedge clk) disable iff (rst)
        rect_valid |=> !rect_valid);

    // R3
    rect_shape_chk: assert property (@(posedge clk) disable iff (rst)
        rect_valid |-> (rect_h != '0) && (int'(rect_h) % LINES_PER_PAGE == 0)
                       && (int'(rect_y) % LINES_PER_PAGE == 0));

    // R4
    rect_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rect_valid |-> (int'(rect_y) + int'(rect_h) <= TOTAL_LINES));

    // R9
    rect_width_chk: assert property (@(posedge clk) disable iff (rst)
        rect_valid |-> (rect_w == $past(disp_width)));
endmodule

bind page_dirty_scanner pds_checker #(
    .NUM_PAGES      (NUM_PAGES),
    .LINES_PER_PAGE (LINES_PER_PAGE),
    .WIDTH_W        (WIDTH_W),
    .LINE_W         (LINE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .disp_width (disp_width),
    .rect_valid (rect_valid),
    .rect_y     (rect_y),
    .rect_h     (rect_h),
    .rect_w     (rect_w),
    .scan_done  (scan_done)
);

// File: tb/page_dirty_scanner_test.sv
module page_dirty_scanner_test;
    localparam int N  = 16;
    localparam int LP = 4;
    localparam int WW = 11;
    localparam int PW = $clog2(N);
    localparam int LW = $clog2(N * LP + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_24 = 1'b0;
    logic [WW-1:0] disp_width = 11'd640;
    logic          snoop_valid = 1'b0;
    logic [1:0]    snoop_plane = 2'd0;
    logic [PW-1:0] snoop_page = '0;
    logic          invalidate = 1'b0;
    logic          palette_chg = 1'b0;
    logic          scan_start = 1'b0;
    logic          rect_valid;
    logic [LW-1:0] rect_y, rect_h;
    logic [WW-1:0] rect_w;
    logic          scan_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    page_dirty_scanner #(.NUM_PAGES(N), .LINES_PER_PAGE(LP), .WIDTH_W(WW)) uut (
        .clk(clk), .rst(rst), .mode_24(mode_24), .disp_width(disp_width),
        .snoop_valid(snoop_valid), .snoop_plane(snoop_plane), .snoop_page(snoop_page),
        .invalidate(invalidate), .palette_chg(palette_chg), .scan_start(scan_start),
        .rect_valid(rect_valid), .rect_y(rect_y), .rect_h(rect_h), .rect_w(rect_w),
        .scan_done(scan_done)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_bits [3][N];
    bit m_prot [N];
    int m_state = 0;      // 0 idle, 1 scanning, 2 finishing
    int m_idx, m_open, m_start, m_lo, m_hi;
    int e_rv, e_y, e_h, e_w, e_done;

    int q_y[$];
    int q_h[$];
    int got_done = 0;

    always @(posedge clk) begin
        int old_state;
        bit dirty;
        e_rv = 0; e_done = 0;
        if (rst) begin
            for (int p = 0; p < 3; p++) for (int i = 0; i < N; i++) m_bits[p][i] = 0;
            m_state = 0; e_y = 0; e_h = 0; e_w = 0;
        end else begin
            old_state = m_state;
            e_w = int'(disp_width);
            if (m_state == 0) begin
                if (scan_start) begin
                    m_state = 1; m_idx = 0; m_open = 0; m_lo = 1 << 30; m_hi = 0;
                    for (int i = 0; i < N; i++) m_prot[i] = 0;
                end
            end else if (m_state == 1) begin
                dirty = m_bits[0][m_idx] || (mode_24 && (m_bits[1][m_idx] || m_bits[2][m_idx]));
                if (dirty) begin
                    if (m_open == 0) begin m_open = 1; m_start = m_idx; end
                    if (m_idx < m_lo) m_lo = m_idx;
                    if (m_idx > m_hi) m_hi = m_idx;
                end else if (m_open != 0) begin
                    e_rv = 1; e_y = m_start * LP; e_h = (m_idx - m_start) * LP; m_open = 0;
                end
                if (m_idx == N - 1) m_state = 2; else m_idx++;
            end else begin
                if (m_open != 0) begin
                    e_rv = 1; e_y = m_start * LP; e_h = (N - m_start) * LP; m_open = 0;
                end
                e_done = 1;
                if (m_hi >= m_lo)
                    for (int i = m_lo; i <= m_hi; i++)
                        if (!m_prot[i]) for (int p = 0; p < 3; p++) m_bits[p][i] = 0;
                m_state = 0;
            end
            if (old_state != 0) begin
                if (snoop_valid) m_prot[snoop_page] = 1;
                if (invalidate || palette_chg) for (int i = 0; i < N; i++) m_prot[i] = 1;
            end
            if (snoop_valid && snoop_plane < 3) m_bits[snoop_plane][snoop_page] = 1;
            if (invalidate || palette_chg)
                for (int i = 0; i < N; i++) begin
                    m_bits[0][i] = 1;
                    if (mode_24) begin m_bits[1][i] = 1; m_bits[2][i] = 1; end
                end
        end
        #2;
        check("R3 rect_valid", int'(rect_valid), e_rv);
        check("R2 scan_done", int'(scan_done), e_done);
        if (e_rv != 0) begin
            check("R3 rect_y", int'(rect_y), e_y);
            check("R3 rect_h", int'(rect_h), e_h);
            check("R9 rect_w", int'(rect_w), e_w);
        end
        if (rect_valid) begin q_y.push_back(int'(rect_y)); q_h.push_back(int'(rect_h)); end
        if (scan_done) got_done++;
    end

    // ---------------- stimulus helpers ----------------
    task automatic snoop(input int plane, input int page);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_plane = 2'(plane); snoop_page = PW'(page);
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    task automatic pulse_mark(input bit pal);
        @(negedge clk);
        if (pal) palette_chg = 1'b1; else invalidate = 1'b1;
        @(negedge clk);
        palette_chg = 1'b0; invalidate = 1'b0;
    endtask

    task automatic begin_scan();
        q_y.delete(); q_h.delete(); got_done = 0;
        @(negedge clk); scan_start = 1'b1;
        @(negedge clk); scan_start = 1'b0;
    endtask

    task automatic finish_scan(input string tag, input int n,
                               input int y0, input int h0, input int y1, input int h1);
        while (got_done == 0) @(negedge clk);
        check({tag, " rect count"}, q_y.size(), n);
        if (n > 0 && q_y.size() > 0) begin
            check({tag, " y0"}, q_y[0], y0); check({tag, " h0"}, q_h[0], h0);
        end
        if (n > 1 && q_y.size() > 1) begin
            check({tag, " y1"}, q_y[1], y1); check({tag, " h1"}, q_h[1], h1);
        end
    endtask

    task automatic do_scan(input string tag, input int n,
                           input int y0, input int h0, input int y1, input int h1);
        begin_scan();
        finish_scan(tag, n, y0, h0, y1, h1);
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1 rect_valid", int'(rect_valid), 0);
        check("R1 scan_done", int'(scan_done), 0);
        check("R1 rect_w", int'(rect_w), 0);
        rst = 1'b0;

        // R2: empty scan, timing of done
        begin_scan();
        cnt = 1;
        while (got_done == 0) begin @(negedge clk); cnt++; end
        check("R2 cycles to done", cnt, N + 2);
        check("R1 no rect after reset", q_y.size(), 0);

        // R3: two runs closed by clean pages
        snoop(0, 2); snoop(0, 3); snoop(0, 4); snoop(0, 9);
        do_scan("R3", 2, 8, 12, 36, 4);

        // R4: run open at the bottom, R9 with another width
        disp_width = 11'd1024;
        snoop(0, 14); snoop(0, 15);
        do_scan("R4", 1, 56, 8, 0, 0);

        // R5: window clear spans all planes, page outside kept
        mode_24 = 1'b0;
        snoop(1, 0); snoop(0, 5);
        do_scan("R5 8-bit", 1, 20, 4, 0, 0);
        mode_24 = 1'b1;
        do_scan("R5 kept outside window", 1, 0, 4, 0, 0);
        do_scan("R5 cleared", 0, 0, 0, 0, 0);

        // R8: control plane alone dirties a band in 24-bit mode
        snoop(2, 7);
        do_scan("R8", 1, 28, 4, 0, 0);

        // R7: invalidate in 8-bit mode, palette change in 24-bit mode
        mode_24 = 1'b0;
        pulse_mark(1'b0);
        do_scan("R7 invalidate", 1, 0, 64, 0, 0);
        mode_24 = 1'b1;
        do_scan("R7 aux planes untouched", 0, 0, 0, 0, 0);
        pulse_mark(1'b1);
        do_scan("R7 palette", 1, 0, 64, 0, 0);
        do_scan("R7 cleared", 0, 0, 0, 0, 0);

        // R6 and R10: snoops during a scan are protected, restarts ignored
        snoop(0, 5);
        begin_scan();
        repeat (8) @(negedge clk);
        snoop_valid = 1'b1; snoop_plane = 2'd0; snoop_page = 4'd1; scan_start = 1'b1;
        @(negedge clk);
        snoop_page = 4'd5;
        @(negedge clk);
        snoop_valid = 1'b0; scan_start = 1'b0;
        finish_scan("R6 during scan", 1, 20, 4, 0, 0);
        repeat (N + 4) @(negedge clk);
        check("R10 single done", got_done, 1);
        do_scan("R6 protected pages", 2, 4, 4, 20, 4);
        do_scan("R6 cleared after", 0, 0, 0, 0, 0);

        // R6: snoop in the final scan cycle survives the clear
        snoop(0, 10);
        begin_scan();
        repeat (N - 1) @(negedge clk);
        snoop_valid = 1'b1; snoop_plane = 2'd0; snoop_page = 4'd10;
        @(negedge clk);
        snoop_valid = 1'b0;
        finish_scan("R6 last cycle", 1, 40, 4, 0, 0);
        do_scan("R6 last cycle kept", 1, 40, 4, 0, 0);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule